// File: doc/BRIEF.md
# Base-Bound Address Relocation and Protection Unit

This unit sits between a simple processor's load/store path and the memory and device fabric. It turns each 32-bit logical address into a physical address through a base register and a bound register. The processor's mode decides whether that happens. In user mode every access is checked against the bound and then moved by the base. In system mode the logical address passes through unchanged. Every physical address is also classified as either ordinary memory or device-register space, and exactly one matching request strobe is raised.

An access that breaks the bound raises no strobe in its own cycle. One cycle later it shows up as a registered protection fault with a cause code, which goes to the interrupt logic. The base and bound registers can be loaded only while the processor is in system mode. A load attempted from user mode is dropped and reported as an illegal-operation fault.

Top module: `seg_xlate`

## Requirements
- R1: After reset, base and bound are zero and `fault`/`fault_cause` are 0. With bound at zero, every user-mode access therefore violates the limit.
- R2: `mode_sys`=1 selects system mode and `mode_sys`=0 selects user mode.
- R3: In system mode, `phys_addr` equals `acc_laddr` in the same cycle.
- R4: In user mode, `phys_addr` equals `acc_laddr + base` modulo 2^32 in the same cycle.
- R5: A valid user-mode access with `acc_laddr >= bound` sets `fault`=1 and `fault_cause`=2 on the next clock edge. An address of bound-1 does not fault.
- R6: A valid access that violates the limit raises neither `mem_req` nor `io_req` in its own cycle.
- R7: For a valid, non-faulting access, `mem_req` is 1 when `phys_addr < 0xF0000000` and `io_req` is 1 when `phys_addr >= 0xF0000000`. The two are never 1 together.
- R8: In system mode, `cfg_wr_base` or `cfg_wr_bound` loads `cfg_wdata` into that register at the clock edge. The new value governs accesses from the next cycle on.
- R9: A write strobe in user mode leaves both registers unchanged and sets `fault`=1 with `fault_cause`=1 on the next edge.
- R10: If a limit violation and a user-mode write strobe occur in the same cycle, `fault_cause` is 2.
- R11: `fault` is high for exactly one cycle per offending cycle. Whenever `fault` is 0, `fault_cause` is 0.
- R12: With `acc_valid`=0, no strobe is raised and no limit fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sys | input | 1 | Processor mode, 1 = system, 0 = user |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_laddr | input | 32 | Logical address of the access |
| cfg_wr_base | input | 1 | Write strobe for the base register |
| cfg_wr_bound | input | 1 | Write strobe for the bound register |
| cfg_wdata | input | 32 | Data for a register write |
| phys_addr | output | 32 | Physical address (combinational) |
| mem_req | output | 1 | Memory-space request strobe (combinational) |
| io_req | output | 1 | Device-space request strobe (combinational) |
| fault | output | 1 | Registered protection fault pulse |
| fault_cause | output | 2 | Registered cause: 0 none, 1 illegal write, 2 limit violation |

## Verification
The bound checker checks the following on every clock:
- the pass-through and relocation arithmetic;
- strobe suppression on a limit violation;
- mutual exclusion and correct region of the strobes;
- the one-cycle latency of the fault and its cause;
- that both registers stay frozen while in user mode.

Some behaviour appears only in the bench's scenarios, because only they run the sequences that expose it:
- the reset-zero bound making every user access fault;
- wrap-around at 2^32;
- the exact limit edge at bound-1 versus bound;
- cause priority when a user write and a violation collide;
- that a refused write truly leaves the old base in effect.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   localparam int unsigned CAUSE_W = 2;
   typedef logic [CAUSE_W-1:0] cause_t;
   localparam cause_t CAUSE_NONE  = 2'd0;
   localparam cause_t CAUSE_ILL   = 2'd1;
   localparam cause_t CAUSE_BOUND = 2'd2;
   localparam int unsigned NUM_CFG = 2;
   localparam int unsigned IDX_BASE  = 0;
   localparam int unsigned IDX_BOUND = 1;
endpackage

// File: rtl/seg_xlate_cfg.sv
module seg_xlate_cfg
   import seg_xlate_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           mode_sys,
   input  logic [NUM_CFG-1:0]             wr_req,
   input  logic [ADDR_W-1:0]              wdata,
   output logic [NUM_CFG-1:0][ADDR_W-1:0] cfg_q,
   output logic                           wr_illegal
);
   logic [NUM_CFG-1:0] wr_ok;

   assign wr_ok      = wr_req & {NUM_CFG{mode_sys}};
   assign wr_illegal = (|wr_req) & ~mode_sys;

   for (genvar i = 0; i < NUM_CFG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            cfg_q[i] <= '0;
         else if (wr_ok[i])
            cfg_q[i] <= wdata;
      end
   end
endmodule

// File: rtl/seg_xlate_map.sv
module seg_xlate_map #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              user,
   input  logic [ADDR_W-1:0] laddr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] bound,
   output logic [ADDR_W-1:0] paddr,
   output logic              over_limit
);
   logic [ADDR_W-1:0] moved;

   assign moved      = laddr + base;
   assign paddr      = user ? moved : laddr;
   assign over_limit = user & (laddr >= bound);
endmodule

// File: rtl/seg_xlate_region.sv
module seg_xlate_region #(
   parameter int unsigned       ADDR_W  = 32,
   parameter logic [ADDR_W-1:0] IO_BASE = 32'hF000_0000
) (
   input  logic [ADDR_W-1:0] paddr,
   output logic              is_io
);
   localparam logic [ADDR_W-1:0] LOW_MASK   = {4'b0000, {(ADDR_W-4){1'b1}}};
   localparam bit                NIBBLE_CUT = ((IO_BASE & LOW_MASK) == '0);

   if (NIBBLE_CUT) begin : g_nibble
      assign is_io = ((paddr & ~LOW_MASK) >= IO_BASE);
   end else begin : g_full
      assign is_io = (paddr >= IO_BASE);
   end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int unsigned       ADDR_W  = 32,
   parameter logic [ADDR_W-1:0] IO_BASE = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_sys,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_laddr,
   input  logic              cfg_wr_base,
   input  logic              cfg_wr_bound,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] phys_addr,
   output logic              mem_req,
   output logic              io_req,
   output logic              fault,
   output logic [CAUSE_W-1:0] fault_cause
);
   if (ADDR_W < 8) begin : g_bad_width
      $error("seg_xlate: ADDR_W must be at least 8");
   end
   if (IO_BASE == '0) begin : g_bad_split
      $error("seg_xlate: IO_BASE must leave some memory space");
   end

   logic [NUM_CFG-1:0]             wr_req;
   logic [NUM_CFG-1:0][ADDR_W-1:0] cfg_q;
   logic [ADDR_W-1:0]              base_q;
   logic [ADDR_W-1:0]              bound_q;
   logic                           wr_illegal;
   logic                           over_limit;
   logic                           viol;
   logic                           go;
   logic                           is_io;
   cause_t                         cause_d;

   assign wr_req[IDX_BASE]  = cfg_wr_base;
   assign wr_req[IDX_BOUND] = cfg_wr_bound;
   assign base_q            = cfg_q[IDX_BASE];
   assign bound_q           = cfg_q[IDX_BOUND];

   seg_xlate_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sys  (mode_sys),
      .wr_req    (wr_req),
      .wdata     (cfg_wdata),
      .cfg_q     (cfg_q),
      .wr_illegal(wr_illegal)
   );

   seg_xlate_map #(.ADDR_W(ADDR_W)) u_map (
      .user      (~mode_sys),
      .laddr     (acc_laddr),
      .base      (base_q),
      .bound     (bound_q),
      .paddr     (phys_addr),
      .over_limit(over_limit)
   );

   seg_xlate_region #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_region (
      .paddr(phys_addr),
      .is_io(is_io)
   );

   assign viol    = acc_valid & over_limit;
   assign go      = acc_valid & ~viol;
   assign mem_req = go & ~is_io;
   assign io_req  = go & is_io;

   always_comb begin
      if (viol)
         cause_d = CAUSE_BOUND;
      else if (wr_illegal)
         cause_d = CAUSE_ILL;
      else
         cause_d = CAUSE_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault       <= 1'b0;
         fault_cause <= CAUSE_NONE;
      end else begin
         fault       <= viol | wr_illegal;
         fault_cause <= cause_d;
      end
   end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int unsigned       ADDR_W  = 32,
   parameter logic [ADDR_W-1:0] IO_BASE = 32'hF000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_sys,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_laddr,
   input logic              cfg_wr_base,
   input logic              cfg_wr_bound,
   input logic [ADDR_W-1:0] cfg_wdata,
   input logic [ADDR_W-1:0] phys_addr,
   input logic              mem_req,
   input logic              io_req,
   input logic              fault,
   input logic [1:0]        fault_cause,
   input logic [ADDR_W-1:0] base_q,
   input logic [ADDR_W-1:0] bound_q
);
   logic limit_hit;
   assign limit_hit = acc_valid && !mode_sys && (acc_laddr >= bound_q);

   a_r3_sys_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sys |-> phys_addr == acc_laddr);

   a_r4_user_reloc: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_sys |-> phys_addr == ADDR_W'(acc_laddr + base_q));

   a_r5_limit_fault: assert property (@(posedge clk) disable iff (!rst_n)
      limit_hit |=> fault && fault_cause == 2'd2);

   a_r6_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      limit_hit |-> !mem_req && !io_req);

   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && io_req));

   a_r7_mem_region: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> phys_addr < IO_BASE);

   a_r7_io_region: assert property (@(posedge clk) disable iff (!rst_n)
      io_req |-> phys_addr >= IO_BASE);

   a_r8_base_load: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sys && cfg_wr_base |=> base_q == $past(cfg_wdata));

   a_r8_bound_load: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sys && cfg_wr_bound |=> bound_q == $past(cfg_wdata));

   a_r9_user_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_sys |=> $stable(base_q) && $stable(bound_q));

   a_r9_ill_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_sys && (cfg_wr_base || cfg_wr_bound) && !limit_hit
      |=> fault && fault_cause == 2'd1);

   a_r11_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |-> fault_cause == 2'd0);

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !mem_req && !io_req);
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_sys    (mode_sys),
   .acc_valid   (acc_valid),
   .acc_laddr   (acc_laddr),
   .cfg_wr_base (cfg_wr_base),
   .cfg_wr_bound(cfg_wr_bound),
   .cfg_wdata   (cfg_wdata),
   .phys_addr   (phys_addr),
   .mem_req     (mem_req),
   .io_req      (io_req),
   .fault       (fault),
   .fault_cause (fault_cause),
   .base_q      (base_q),
   .bound_q     (bound_q)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        mode_sys;
   logic        acc_valid;
   logic [31:0] acc_laddr;
   logic        cfg_wr_base;
   logic        cfg_wr_bound;
   logic [31:0] cfg_wdata;
   logic [31:0] phys_addr;
   logic        mem_req;
   logic        io_req;
   logic        fault;
   logic [1:0]  fault_cause;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   seg_xlate u_seg_xlate (
      .clk(clk), .rst_n(rst_n), .mode_sys(mode_sys), .acc_valid(acc_valid),
      .acc_laddr(acc_laddr), .cfg_wr_base(cfg_wr_base), .cfg_wr_bound(cfg_wr_bound),
      .cfg_wdata(cfg_wdata), .phys_addr(phys_addr), .mem_req(mem_req),
      .io_req(io_req), .fault(fault), .fault_cause(fault_cause)
   );

   // {mode, valid, laddr, exp_phys, exp_mem, exp_io, exp_fault, exp_cause}
   // Config in force: base 0x1000_0000, bound 0x0001_0000.
   localparam int NV = 8;
   localparam logic [70:0] VEC [NV] = '{
      {1'b1, 1'b1, 32'h0000_1234, 32'h0000_1234, 1'b1, 1'b0, 1'b0, 2'd0}, // R3 R7
      {1'b1, 1'b1, 32'hF000_0008, 32'hF000_0008, 1'b0, 1'b1, 1'b0, 2'd0}, // R3 R7
      {1'b1, 1'b1, 32'hEFFF_FFFF, 32'hEFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0}, // R7 edge
      {1'b0, 1'b1, 32'h0000_0010, 32'h1000_0010, 1'b1, 1'b0, 1'b0, 2'd0}, // R4
      {1'b0, 1'b1, 32'h0000_FFFF, 32'h1000_FFFF, 1'b1, 1'b0, 1'b0, 2'd0}, // R5 bound-1
      {1'b0, 1'b1, 32'h0001_0000, 32'h1001_0000, 1'b0, 1'b0, 1'b1, 2'd2}, // R5 R6
      {1'b0, 1'b0, 32'h0001_0020, 32'h1001_0020, 1'b0, 1'b0, 1'b0, 2'd0}, // R12
      {1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 2'd0}  // R7 top
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      mode_sys = 1'b1; acc_valid = 1'b0; acc_laddr = '0;
      cfg_wr_base = 1'b0; cfg_wr_bound = 1'b0; cfg_wdata = '0;
   endtask

   task automatic sys_write(input bit to_base, input logic [31:0] val);
      @(negedge clk);
      idle();
      cfg_wr_base  = to_base;
      cfg_wr_bound = !to_base;
      cfg_wdata    = val;
      @(posedge clk); #1;
      chk("R8 no fault on system write", {31'd0, fault}, 32'd0);
   endtask

   // drive one access at negedge, check comb outputs, then the registered fault
   task automatic access(input string req, input bit m, input bit v, input logic [31:0] a,
                         input logic [31:0] ep, input bit em, input bit ei,
                         input bit ef, input logic [1:0] ec);
      @(negedge clk);
      idle();
      mode_sys = m; acc_valid = v; acc_laddr = a;
      #1;
      chk({req, " phys"}, phys_addr, ep);
      chk({req, " mem_req"}, {31'd0, mem_req}, {31'd0, em});
      chk({req, " io_req"}, {31'd0, io_req}, {31'd0, ei});
      @(posedge clk); #1;
      chk({req, " fault"}, {31'd0, fault}, {31'd0, ef});
      chk({req, " cause"}, {30'd0, fault_cause}, {30'd0, ec});
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset fault", {31'd0, fault}, 32'd0);
      chk("R1 reset cause", {30'd0, fault_cause}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: zero bound, every user access faults; R2: mode 1 passes through
      access("R1 zero bound user", 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 2'd2);
      access("R2 system bypass", 1'b1, 1'b1, 32'h0000_0040, 32'h0000_0040, 1'b1, 1'b0, 1'b0, 2'd0);
      access("R11 fault clears", 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0);

      sys_write(1'b1, 32'h1000_0000);
      sys_write(1'b0, 32'h0001_0000);

      for (int i = 0; i < NV; i++) begin
         access($sformatf("vec%0d", i), VEC[i][70], VEC[i][69], VEC[i][68:37], VEC[i][36:5],
                VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0]);
      end

      // R4 wrap-around and I/O region under relocation
      sys_write(1'b1, 32'hF000_0000);
      sys_write(1'b0, 32'hFFFF_FFFF);
      access("R4 user into io", 1'b0, 1'b1, 32'h0000_0004, 32'hF000_0004, 1'b0, 1'b1, 1'b0, 2'd0);
      access("R4 wrap", 1'b0, 1'b1, 32'h1000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 2'd0);

      // R9: user-mode write is refused and flagged
      @(negedge clk);
      idle();
      mode_sys = 1'b0; cfg_wr_base = 1'b1; cfg_wdata = 32'h1234_5678;
      @(posedge clk); #1;
      chk("R9 fault", {31'd0, fault}, 32'd1);
      chk("R9 cause", {30'd0, fault_cause}, 32'd1);
      access("R9 base unchanged", 1'b0, 1'b1, 32'h0000_0004, 32'hF000_0004, 1'b0, 1'b1, 1'b0, 2'd0);

      // R10: violation and illegal write together, cause 2 wins
      @(negedge clk);
      idle();
      mode_sys = 1'b0; acc_valid = 1'b1; acc_laddr = 32'hFFFF_FFFF;
      cfg_wr_bound = 1'b1; cfg_wdata = 32'h0;
      #1;
      chk("R6 collide no mem", {31'd0, mem_req}, 32'd0);
      chk("R6 collide no io", {31'd0, io_req}, 32'd0);
      @(posedge clk); #1;
      chk("R10 fault", {31'd0, fault}, 32'd1);
      chk("R10 cause", {30'd0, fault_cause}, 32'd2);
      // R9: bound not overwritten by that user write
      access("R9 bound unchanged", 1'b0, 1'b1, 32'hFFFF_FFFE, 32'hEFFF_FFFE, 1'b1, 1'b0, 1'b0, 2'd0);

      // R11: single-cycle pulse after an idle cycle
      access("R11 idle", 1'b0, 1'b0, 32'h0, 32'hF000_0000, 1'b0, 1'b0, 1'b0, 2'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule